// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block holds a small configuration register space that host software reaches through two byte-wide ports. Writing a byte to the index port selects a register. Reading or writing the data port then accesses that register. The space is locked after reset. While it is locked, index-port writes are fed to a key detector, and data-port traffic has no effect. Once a fixed four-byte key has arrived on the index port, the space opens. It stays open until software writes the exit command to the control register.

The register space has two parts. The global registers are a 16-bit chip identifier, a revision nibble and a bank-select register. The bank-select register holds a device number, and that number chooses which per-device register set answers at the banked indices. Each device has an enable bit and a 16-bit base address. These values leave the block on `dev_active` and `dev_base`, where other logic on the chip uses them. The bus decoding that turns I/O cycles at addresses 0x2E (index) and 0x2F (data) into the `idx_wr`, `data_wr` and `rdata` paths is outside this block.

Top module: `cfg_index_port`

## Requirements
- R1: After reset the space is locked: `cfg_open` is 0, `rdata` is 0xFF, and every `dev_active` and `dev_base` bit is 0.
- R2: The space opens when the bytes 0x87, 0x01, 0x55, 0x55 are written in that order to the index port. `cfg_open` rises in the cycle after the fourth write and not before it.
- R3: While the space is locked, an index byte that does not match the expected key byte resets the key detector. If that byte is 0x87, it counts as the first key byte instead, so the rest of the match starts from the second byte.
- R4: While the space is locked, `rdata` is 0xFF and data-port writes change no register.
- R5: While the space is open, an index write latches the register index. `rdata` shows the selected register combinationally in the cycle after the latch. The index is 0x00 when the space opens.
- R6: Index 0x20 reads the high byte of the chip identifier and index 0x21 reads the low byte. Index 0x22 reads the revision in bits 3:0, with bits 7:4 reading 0. Writes to these three indices are ignored.
- R7: Index 0x07 is a read/write device-number register. With default parameters, device 0 answers at device number 0x07 and device 1 at 0x09. For any other number, indices 0x30, 0x60 and 0x61 read 0x00 and writes to them are ignored.
- R8: Index 0x30 of the selected device stores data bit 0 as the device enable, shown on `dev_active[i]`. Bits 7:1 read as 0.
- R9: Index 0x60 holds bits 15:8 and index 0x61 holds bits 7:0 of the selected device's base address, shown on `dev_base[16*i +: 16]`.
- R10: Every index that is not listed in R6 to R9 reads 0x00 while the space is open. This includes control index 0x02.
- R11: A data write to index 0x02 with bit 1 set locks the space in the next cycle. A write to 0x02 with bit 1 clear has no effect. Register contents are kept across the lock, and reopening the space requires the full key again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| idx_wr | input | 1 | One-cycle strobe: `wdata` is written to the index port |
| data_wr | input | 1 | One-cycle strobe: `wdata` is written to the data port |
| wdata | input | 8 | Write data for either port |
| rdata | output | 8 | Data-port read value |
| cfg_open | output | 1 | Configuration space is unlocked |
| dev_active | output | NDEV | Enable bit of each device |
| dev_base | output | 16*NDEV | Base address of each device, device i in bits 16*i+15:16*i |

## Verification
The hardest case to reach from the ports is the key detector recovering after a wrong byte. Whether it recovers depends on which step the match had reached and on whether the wrong byte was itself 0x87. The stimulus covers every step from the first to the fourth and every byte value at that step. Each trial ends with the suffix 0x01, 0x55, 0x55, which opens the space only when the detector is sitting at step two, so the port shows exactly where the detector landed. The device-number register is also swept over all 256 values with writes to the enable and base registers, to show that only the two configured numbers reach any storage.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam logic [7:0] KEY_0 = 8'h87;
    localparam logic [7:0] KEY_1 = 8'h01;
    localparam logic [7:0] KEY_2 = 8'h55;
    localparam logic [7:0] KEY_3 = 8'h55;

    localparam logic [7:0] IDX_CTRL  = 8'h02;
    localparam logic [7:0] IDX_BANK  = 8'h07;
    localparam logic [7:0] IDX_ID_HI = 8'h20;
    localparam logic [7:0] IDX_ID_LO = 8'h21;
    localparam logic [7:0] IDX_REV   = 8'h22;
    localparam logic [7:0] IDX_ACT   = 8'h30;
    localparam logic [7:0] IDX_BA_HI = 8'h60;
    localparam logic [7:0] IDX_BA_LO = 8'h61;

    localparam int EXIT_BIT = 1;

    typedef struct packed {
        logic [1:0] step;
        logic       open;
    } key_st_t;

    typedef struct packed {
        logic        act;
        logic [15:0] base;
    } dev_st_t;

    typedef struct packed {
        logic [7:0] index;
        logic [7:0] bank;
    } top_st_t;

    function automatic logic [7:0] key_at(input logic [1:0] s);
        case (s)
            2'd0:    key_at = KEY_0;
            2'd1:    key_at = KEY_1;
            2'd2:    key_at = KEY_2;
            default: key_at = KEY_3;
        endcase
    endfunction

endpackage

// File: rtl/cfg_key_match.sv
module cfg_key_match
    import cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_byte,
    input  logic       exit_req,
    output logic       open_o
);

    key_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.open) begin
            if (exit_req) begin
                st_d.open = 1'b0;
                st_d.step = 2'd0;
            end
        end else if (key_wr) begin
            if (key_byte == key_at(st_q.step)) begin
                if (st_q.step == 2'd3) begin
                    st_d.open = 1'b1;
                    st_d.step = 2'd0;
                end else begin
                    st_d.step = st_q.step + 2'd1;
                end
            end else if (key_byte == KEY_0) begin
                st_d.step = 2'd1;
            end else begin
                st_d.step = 2'd0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign open_o = st_q.open;

endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
    import cfg_pkg::*;
#(
    parameter logic [7:0] BANK_NUM = 8'h07
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bank_i,
    input  logic [7:0]  idx_i,
    input  logic        wr_en,
    input  logic [7:0]  wdata,
    output logic        active_o,
    output logic [15:0] base_o,
    output logic [7:0]  rd_o
);

    dev_st_t dv_d, dv_q;
    logic    sel;

    assign sel = (bank_i == BANK_NUM);

    always_comb begin
        dv_d = dv_q;
        if (wr_en && sel) begin
            case (idx_i)
                IDX_ACT:   dv_d.act        = wdata[0];
                IDX_BA_HI: dv_d.base[15:8] = wdata;
                IDX_BA_LO: dv_d.base[7:0]  = wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        rd_o = 8'h00;
        if (sel) begin
            case (idx_i)
                IDX_ACT:   rd_o = {7'd0, dv_q.act};
                IDX_BA_HI: rd_o = dv_q.base[15:8];
                IDX_BA_LO: rd_o = dv_q.base[7:0];
                default:   rd_o = 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    assign active_o = dv_q.act;
    assign base_o   = dv_q.base;

endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
    import cfg_pkg::*;
#(
    parameter logic [15:0]    CHIP_ID  = 16'h8712,
    parameter logic [3:0]     CHIP_REV = 4'h3,
    parameter int             NDEV     = 2,
    parameter logic [NDEV*8-1:0] DEV_NUMS = 16'h0907
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               idx_wr,
    input  logic               data_wr,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata,
    output logic               cfg_open,
    output logic [NDEV-1:0]    dev_active,
    output logic [NDEV*16-1:0] dev_base
);

    localparam int BASE_W = 16;

    top_st_t    ts_d, ts_q;
    logic       open_w;
    logic       wr_go;
    logic       exit_req;
    logic [7:0] bank_rd [NDEV];
    logic [7:0] bank_or;

    assign wr_go    = data_wr && open_w;
    assign exit_req = wr_go && (ts_q.index == IDX_CTRL) && wdata[EXIT_BIT];

    cfg_key_match u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (idx_wr && !open_w),
        .key_byte (wdata),
        .exit_req (exit_req),
        .open_o   (open_w)
    );

    for (genvar g = 0; g < NDEV; g++) begin : g_dev
        cfg_dev_bank #(
            .BANK_NUM (DEV_NUMS[g*8 +: 8])
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .bank_i   (ts_q.bank),
            .idx_i    (ts_q.index),
            .wr_en    (wr_go),
            .wdata    (wdata),
            .active_o (dev_active[g]),
            .base_o   (dev_base[g*BASE_W +: BASE_W]),
            .rd_o     (bank_rd[g])
        );
    end

    always_comb begin
        ts_d = ts_q;
        if (!open_w) begin
            ts_d.index = 8'h00;
        end else begin
            if (idx_wr)                             ts_d.index = wdata;
            if (wr_go && ts_q.index == IDX_BANK)    ts_d.bank  = wdata;
            if (exit_req)                           ts_d.index = 8'h00;
        end
    end

    always_comb begin
        bank_or = 8'h00;
        for (int i = 0; i < NDEV; i++) bank_or = bank_or | bank_rd[i];
    end

    always_comb begin
        if (!open_w) begin
            rdata = 8'hFF;
        end else begin
            case (ts_q.index)
                IDX_BANK:  rdata = ts_q.bank;
                IDX_ID_HI: rdata = CHIP_ID[15:8];
                IDX_ID_LO: rdata = CHIP_ID[7:0];
                IDX_REV:   rdata = {4'h0, CHIP_REV};
                default:   rdata = bank_or;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_d;
    end

    assign cfg_open = open_w;

endmodule

// File: rtl/cfg_index_port_chk.sv
module cfg_index_port_chk #(
    parameter int NDEV = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               idx_wr,
    input logic               data_wr,
    input logic [7:0]         wdata,
    input logic [7:0]         rdata,
    input logic               cfg_open,
    input logic [NDEV-1:0]    dev_active,
    input logic [NDEV*16-1:0] dev_base
);

    a_r4_locked_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |-> rdata == 8'hFF);

    a_r4_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && data_wr) |=> ($stable(dev_active) && $stable(dev_base)));

    a_r2_open_after_last_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> ($past(idx_wr) && $past(wdata) == 8'h55));

    a_r11_lock_by_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_open) |-> ($past(data_wr) && $past(wdata[1])));

    a_r8_active_needs_open_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dev_active) |-> ($past(data_wr) && $past(cfg_open)));

    a_r9_base_needs_open_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dev_base) |-> ($past(data_wr) && $past(cfg_open)));

endmodule

bind cfg_index_port cfg_index_port_chk #(.NDEV(NDEV)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx_wr     (idx_wr),
    .data_wr    (data_wr),
    .wdata      (wdata),
    .rdata      (rdata),
    .cfg_open   (cfg_open),
    .dev_active (dev_active),
    .dev_base   (dev_base)
);

// File: tb/tb_cfg_index_port.sv
module tb_cfg_index_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        idx_wr = 1'b0;
    logic        data_wr = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic        cfg_open;
    logic [1:0]  dev_active;
    logic [31:0] dev_base;

    int n_cmp = 0;
    int n_bad = 0;

    logic        m_open;
    logic [7:0]  m_idx;
    logic [7:0]  m_bank;
    logic        m_act [2];
    logic [15:0] m_base [2];

    always #2 clk = ~clk;

    cfg_index_port dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx_wr     (idx_wr),
        .data_wr    (data_wr),
        .wdata      (wdata),
        .rdata      (rdata),
        .cfg_open   (cfg_open),
        .dev_active (dev_active),
        .dev_base   (dev_base)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int bank_of(input logic [7:0] b);
        if (b == 8'h07) return 0;
        if (b == 8'h09) return 1;
        return -1;
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] ix);
        int k;
        if (!m_open) return 8'hFF;
        k = bank_of(m_bank);
        case (ix)
            8'h07: return m_bank;
            8'h20: return 8'h87;
            8'h21: return 8'h12;
            8'h22: return 8'h03;
            8'h30: return (k < 0) ? 8'h00 : {7'd0, m_act[k]};
            8'h60: return (k < 0) ? 8'h00 : m_base[k][15:8];
            8'h61: return (k < 0) ? 8'h00 : m_base[k][7:0];
            default: return 8'h00;
        endcase
    endfunction

    task automatic wr_idx(input logic [7:0] v);
        @(negedge clk); idx_wr = 1'b1; wdata = v;
        @(negedge clk); idx_wr = 1'b0;
        if (m_open) m_idx = v;
    endtask

    task automatic wr_dat(input logic [7:0] v);
        int k;
        @(negedge clk); data_wr = 1'b1; wdata = v;
        @(negedge clk); data_wr = 1'b0;
        if (m_open) begin
            k = bank_of(m_bank);
            case (m_idx)
                8'h02: if (v[1]) begin m_open = 1'b0; m_idx = 8'h00; end
                8'h07: m_bank = v;
                8'h30: if (k >= 0) m_act[k] = v[0];
                8'h60: if (k >= 0) m_base[k][15:8] = v;
                8'h61: if (k >= 0) m_base[k][7:0] = v;
                default: ;
            endcase
        end
    endtask

    task automatic send_key();
        wr_idx(8'h87); wr_idx(8'h01); wr_idx(8'h55); wr_idx(8'h55);
        m_open = 1'b1; m_idx = 8'h00;
    endtask

    task automatic chk_outs(input string req);
        chk(req, {30'd0, dev_active}, {30'd0, m_act[1], m_act[0]});
        chk(req, dev_base, {m_base[1], m_base[0]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] kb [4];
        kb[0] = 8'h87; kb[1] = 8'h01; kb[2] = 8'h55; kb[3] = 8'h55;
        m_open = 1'b0; m_idx = 8'h00; m_bank = 8'h00;
        m_act[0] = 1'b0; m_act[1] = 1'b0; m_base[0] = '0; m_base[1] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 open", {31'd0, cfg_open}, 32'd0);
        chk("R1 rdata", {24'd0, rdata}, 32'hFF);
        chk_outs("R1 outs");

        // R4 locked: data writes ignored, reads 0xFF
        for (int v = 0; v < 256; v += 17) begin
            wr_dat(v[7:0]);
            chk("R4 rdata", {24'd0, rdata}, 32'hFF);
        end
        chk_outs("R4 outs");

        // R3 every wrong byte at every key step
        for (int pos = 0; pos < 4; pos++) begin
            for (int v = 0; v < 256; v++) begin
                if (v[7:0] == kb[pos]) continue;
                for (int p = 0; p < pos; p++) wr_idx(kb[p]);
                wr_idx(v[7:0]);
                chk("R3 still locked", {31'd0, cfg_open}, 32'd0);
                wr_idx(8'h01); wr_idx(8'h55); wr_idx(8'h55);
                chk("R3 recovery", {31'd0, cfg_open}, {31'd0, v[7:0] == 8'h87});
                if (cfg_open) begin
                    m_open = 1'b1; m_idx = 8'h00;
                    wr_idx(8'h02); wr_dat(8'h02);
                end
            end
        end

        // R2 opens only after the fourth byte
        wr_idx(8'h87); wr_idx(8'h01); wr_idx(8'h55);
        chk("R2 not yet", {31'd0, cfg_open}, 32'd0);
        wr_idx(8'h55);
        m_open = 1'b1; m_idx = 8'h00;
        chk("R2 opened", {31'd0, cfg_open}, 32'd1);
        chk("R5 index zero", {24'd0, rdata}, 32'h00);

        // R6 identifier and revision, read-only
        wr_idx(8'h20); chk("R6 id hi", {24'd0, rdata}, 32'h87);
        wr_dat(8'h00); chk("R6 id hi ro", {24'd0, rdata}, 32'h87);
        wr_idx(8'h21); wr_dat(8'hFF); chk("R6 id lo", {24'd0, rdata}, 32'h12);
        wr_idx(8'h22); wr_dat(8'hFF); chk("R6 rev", {24'd0, rdata}, 32'h03);

        // R8 R9 device registers
        wr_idx(8'h07); wr_dat(8'h07);
        wr_idx(8'h30); wr_dat(8'hFF); chk("R8 act read", {24'd0, rdata}, 32'h01);
        wr_idx(8'h60); wr_dat(8'h12);
        wr_idx(8'h61); wr_dat(8'h34);
        wr_idx(8'h07); wr_dat(8'h09);
        wr_idx(8'h30); wr_dat(8'hFE); chk("R8 bit0 only", {24'd0, rdata}, 32'h00);
        wr_idx(8'h60); wr_dat(8'hBE);
        wr_idx(8'h61); wr_dat(8'hEF);
        chk_outs("R9 outs");

        // R5 R7 R10 full index sweep for three banks
        for (int b = 0; b < 3; b++) begin
            logic [7:0] bn;
            bn = (b == 0) ? 8'h07 : (b == 1) ? 8'h09 : 8'h00;
            wr_idx(8'h07); wr_dat(bn);
            for (int ix = 0; ix < 256; ix++) begin
                wr_idx(ix[7:0]);
                chk("R10 sweep", {24'd0, rdata}, {24'd0, exp_read(ix[7:0])});
            end
        end

        // R7 bank number sweep with writes
        for (int b = 0; b < 256; b++) begin
            wr_idx(8'h07); wr_dat(b[7:0]);
            wr_idx(8'h30); wr_dat({7'd0, ~dev_active[0] ^ b[0]});
            wr_idx(8'h61); wr_dat(b[7:0] ^ 8'h5A);
            chk_outs("R7 bank sweep");
        end

        // R11 control register
        wr_idx(8'h07); wr_dat(8'h07);
        wr_idx(8'h02); wr_dat(8'h00);
        chk("R11 no exit 00", {31'd0, cfg_open}, 32'd1);
        wr_dat(8'hFD);
        chk("R11 no exit FD", {31'd0, cfg_open}, 32'd1);
        wr_dat(8'h02);
        chk("R11 locked", {31'd0, cfg_open}, 32'd0);
        chk("R11 rdata", {24'd0, rdata}, 32'hFF);
        wr_dat(8'h00);
        chk_outs("R11 kept");
        wr_idx(8'h55); wr_idx(8'h55);
        chk("R11 partial key", {31'd0, cfg_open}, 32'd0);
        send_key();
        chk("R11 reopen", {31'd0, cfg_open}, 32'd1);
        chk("R5 index reset", {24'd0, rdata}, 32'h00);
        wr_idx(8'h07); chk("R11 bank kept", {24'd0, rdata}, 32'h07);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule